// File: doc/BRIEF.md
# Synchronizing Button Debouncer

This block takes one raw, asynchronous push-button line and turns it into a clean, single-clock-domain level. The raw line first passes through a two-flop synchronizer inside the block, so no debounce logic ever samples an unsynchronized signal. A hold counter then measures how long the synchronized level has disagreed with the current clean level. The clean level adopts the new value only after that disagreement has lasted a full, parameterized number of consecutive cycles. Any return to the old level before then discards the pending change.

A one-cycle press pulse marks each entry into the pressed level, so downstream logic can count presses without detecting edges itself. The released level is 0 by default, and a parameter selects active-low buttons. The default hold count of 250000 cycles gives 10 ms at 25 MHz. A testbench overrides it with a small value so that short, rapidly toggling stimulus runs quickly.

Top module: `btn_debounce`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `btn_level` equals the released level (0 when ACTIVE_LOW=0, 1 when ACTIVE_LOW=1) and `press_pulse` is 0.
- R2: The raw input passes through two flops before the hold counter sees it. A raw change that is held steady appears on `btn_level` exactly HOLD_CYCLES+2 rising clock edges after the first edge that samples it, and not one edge sooner.
- R3: `btn_level` takes a new value only after the synchronized input has differed from it for HOLD_CYCLES consecutive cycles. A raw pulse that lasts exactly HOLD_CYCLES cycles is therefore accepted.
- R4: A raw excursion shorter than HOLD_CYCLES cycles (for example HOLD_CYCLES-1 cycles) leaves `btn_level` unchanged. The next excursion must then restart its count from zero.
- R5: A press that bounces several times before settling produces exactly one transition of `btn_level` and exactly one `press_pulse`.
- R6: `press_pulse` is high for exactly one cycle, in the cycle in which `btn_level` first shows the pressed level (1 when ACTIVE_LOW=0, 0 when ACTIVE_LOW=1). It never fires on a release.
- R7: HOLD_CYCLES is a parameter with a default of 250000 that can be overridden with any value of at least 1. The counter width follows from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw, asynchronous button line |
| btn_level | output | 1 | Debounced level, same polarity as the raw line |
| press_pulse | output | 1 | One-cycle pulse on entry into the pressed level |

## Verification
With HOLD_CYCLES set to 8, a steady raw change is due on `btn_level` exactly 10 edges after it is driven. The edges break down as two synchronizer edges, seven counting edges and one flipping edge. `press_pulse` is due on that same edge and must be gone one edge later. The bench drives inputs on falling edges and samples on falling edges. It counts falling edges from each drive and checks both edge 9 (no change yet) and edge 10 (change present). Pulses are tallied on every falling edge over a whole bouncy press, so a double trigger shows up in the count.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  // Counter width able to hold values 0 .. hold-1 (at least one bit).
  function automatic int count_width(input int hold);
    int w;
    w = $clog2(hold + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Level a released button drives on the raw line.
  function automatic logic released_level(input bit active_low);
    return active_low ? 1'b1 : 1'b0;
  endfunction

  // Number of edges from a steady raw change to the debounced change.
  function automatic int response_edges(input int hold, input int sync_stages);
    return hold + sync_stages;
  endfunction

endpackage

// File: rtl/dbnc_sync2.sv
module dbnc_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

  // R2: the output only moves to a value the first stage held one edge before
  sync_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_out != $past(sync_out)) |-> (sync_out == $past(chain[STAGES-2])));
endmodule

// File: rtl/dbnc_hold_filter.sv
module dbnc_hold_filter #(
  parameter int   HOLD_CYCLES = 250000,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_lvl,
  output logic clean_lvl
);
  import dbnc_pkg::*;

  localparam int CW = count_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          run_full;
  logic          flip_evt;

  assign differs  = (sync_lvl != clean_lvl);
  assign run_full = (run_cnt == LAST);
  assign flip_evt = differs && run_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt   <= '0;
      clean_lvl <= RST_VAL;
    end else if (!differs) begin
      run_cnt   <= '0;
    end else if (run_full) begin
      run_cnt   <= '0;
      clean_lvl <= sync_lvl;
    end else begin
      run_cnt   <= run_cnt + 1'b1;
    end
  end

  // R3: the clean level only ever moves to the value the synchronized input held
  follow_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (clean_lvl != $past(clean_lvl)) |-> (clean_lvl == $past(sync_lvl)));

  // R4: agreement between input and output always clears the run count
  agree_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_lvl == clean_lvl) |=> (run_cnt == '0));

  // R7: the run count never passes the last legal value
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LAST);
endmodule

// File: rtl/dbnc_press_edge.sv
module dbnc_press_edge #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clean_lvl,
  output logic press_pulse
);
  import dbnc_pkg::*;

  localparam logic RELEASED = released_level(ACTIVE_LOW);

  logic pressed_now;
  logic pressed_prev;

  assign pressed_now = (clean_lvl != RELEASED);

  always_ff @(posedge clk) begin
    if (rst) pressed_prev <= 1'b0;
    else     pressed_prev <= pressed_now;
  end

  assign press_pulse = pressed_now && !pressed_prev;

  // R6: a pulse lasts a single cycle
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);

  // R6: a pulse is only seen while the level is pressed
  pulse_level_chk: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> (clean_lvl != RELEASED));
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int HOLD_CYCLES = 250000,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_level,
  output logic press_pulse
);
  import dbnc_pkg::*;

  localparam logic RELEASED = released_level(ACTIVE_LOW);

  logic synced;

  dbnc_sync2 #(
    .STAGES (2),
    .RST_VAL(RELEASED)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(btn_raw),
    .sync_out(synced)
  );

  dbnc_hold_filter #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .RST_VAL    (RELEASED)
  ) u_filter (
    .clk      (clk),
    .rst      (rst),
    .sync_lvl (synced),
    .clean_lvl(btn_level)
  );

  dbnc_press_edge #(
    .ACTIVE_LOW(ACTIVE_LOW)
  ) u_edge (
    .clk        (clk),
    .rst        (rst),
    .clean_lvl  (btn_level),
    .press_pulse(press_pulse)
  );

  // R1: reset forces the released level
  reset_level_chk: assert property (@(posedge clk)
    rst |=> (btn_level == RELEASED));

  // R5: the debounced level cannot move on two edges in a row
  no_double_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_level != $past(btn_level)) |=> $stable(btn_level));
endmodule

// File: tb/btn_debounce_test.sv
module btn_debounce_test;
  localparam int HOLD = 8;
  localparam int LAT  = HOLD + 2;   // edges from a steady drive to a change

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic raw_n = 1'b1;
  logic lvl, pulse, lvl_n, pulse_n;

  int n_checks = 0;
  int n_fail   = 0;
  int pulse_tally = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  btn_debounce #(.HOLD_CYCLES(HOLD), .ACTIVE_LOW(1'b0)) uut (
    .clk(clk), .rst(rst), .btn_raw(raw), .btn_level(lvl), .press_pulse(pulse));

  btn_debounce #(.HOLD_CYCLES(HOLD), .ACTIVE_LOW(1'b1)) uut_lo (
    .clk(clk), .rst(rst), .btn_raw(raw_n), .btn_level(lvl_n), .press_pulse(pulse_n));

  always @(negedge clk) if (pulse) pulse_tally++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold_for(input logic v, input int n);
    raw = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(lvl == 1'b0, "R1 reset level", lvl, 0);
    chk(pulse == 1'b0, "R1 reset pulse", pulse, 0);
    chk(lvl_n == 1'b1, "R1 active-low reset level", lvl_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(lvl == 1'b0 && pulse == 1'b0, "R1 after release", {lvl, pulse}, 0);
  endtask

  task automatic t_clean_press;
    hold_for(1'b1, LAT - 1);
    chk(lvl == 1'b0, "R2 no change one edge early", lvl, 0);
    @(negedge clk);
    chk(lvl == 1'b1, "R2 R7 level after HOLD+2 edges", lvl, 1);
    chk(pulse == 1'b1, "R6 pulse with press", pulse, 1);
    @(negedge clk);
    chk(pulse == 1'b0, "R6 pulse one cycle", pulse, 0);
  endtask

  task automatic t_release;
    hold_for(1'b0, LAT - 1);
    chk(lvl == 1'b1, "R2 release not early", lvl, 1);
    @(negedge clk);
    chk(lvl == 1'b0, "R2 release level", lvl, 0);
    chk(pulse == 1'b0, "R6 no pulse on release", pulse, 0);
    @(negedge clk);
    chk(pulse == 1'b0, "R6 no pulse after release", pulse, 0);
  endtask

  task automatic t_bounce;
    int start;
    start = pulse_tally;
    hold_for(1'b1, 3); hold_for(1'b0, 2);
    hold_for(1'b1, 5); hold_for(1'b0, 1);
    hold_for(1'b1, 7); hold_for(1'b0, 1);
    chk(lvl == 1'b0, "R4 bounces ignored", lvl, 0);
    hold_for(1'b1, LAT);
    chk(lvl == 1'b1, "R5 settles after final rise", lvl, 1);
    hold_for(1'b1, 5);
    hold_for(1'b0, 2); hold_for(1'b1, 4); hold_for(1'b0, 1); hold_for(1'b1, 6);
    chk(lvl == 1'b1, "R4 release bounces ignored", lvl, 1);
    hold_for(1'b0, LAT + 3);
    chk(lvl == 1'b0, "R5 released after bounce", lvl, 0);
    chk(pulse_tally - start == 1, "R5 exactly one pulse", pulse_tally - start, 1);
  endtask

  task automatic t_boundary;
    hold_for(1'b1, HOLD - 1);
    hold_for(1'b0, LAT + 2);
    chk(lvl == 1'b0, "R4 HOLD-1 pulse rejected", lvl, 0);
    hold_for(1'b1, HOLD);
    hold_for(1'b0, 2);
    chk(lvl == 1'b1, "R3 HOLD pulse accepted", lvl, 1);
    chk(pulse == 1'b1, "R3 R6 pulse on accepted run", pulse, 1);
    hold_for(1'b0, HOLD);
    chk(lvl == 1'b0, "R3 returns after HOLD", lvl, 0);
  endtask

  task automatic t_active_low;
    raw_n = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk(lvl_n == 1'b1, "R2 active-low not early", lvl_n, 1);
    @(negedge clk);
    chk(lvl_n == 1'b0, "R6 active-low pressed level", lvl_n, 0);
    chk(pulse_n == 1'b1, "R6 active-low pulse", pulse_n, 1);
    raw_n = 1'b1;
    repeat (LAT) @(negedge clk);
    chk(lvl_n == 1'b1 && pulse_n == 1'b0, "R6 active-low release no pulse",
        {lvl_n, pulse_n}, 2);
  endtask

  initial begin
    t_reset;
    t_clean_press;
    t_release;
    t_bounce;
    t_boundary;
    t_active_low;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule